// File: doc/BRIEF.md
# Configuration Store Commit Controller

This block sits between a bank of live configuration registers and a nonvolatile store that keeps a copy of them. After every power-up or power-down/up sequence, it refills the live registers from the stored image. On request it writes every live register back into the store. The request is a rising edge of a trigger bit that software writes into the register file. A lock bit and a pin-mode bit act on the device only through the stored image. Setting them in the live registers alone has no effect.

Software uses a byte-wide register port. Register writes take effect at once, except while the controller is busy loading or committing, when writes are dropped. Reads are served at all times. The store is reached through a narrow model interface with an address, write data, a write strobe, read data and a done pulse. A behavioural array model with a configurable write latency stands in for the store. The state machine has four states:
- `ST_LOAD` walks the image into the live registers after reset and then goes to `ST_IDLE`.
- `ST_IDLE` moves to `ST_PUT` on an accepted trigger edge.
- `ST_PUT` issues one store write and always moves to `ST_HOLD`.
- `ST_HOLD` waits for done, then returns to `ST_PUT` for the next byte, or to `ST_IDLE` after the last one.

Top module: `cfg_commit_ctrl`

## Requirements
- R1: After reset is released, the controller copies store addresses 0 to NREG-1 into the live registers of the same index, one per cycle. It then reads back exactly the stored image.
- R2: Register 1 bit 6 reads 1 while the controller is loading or committing and 0 when it is idle. Writes to that bit are not stored.
- R3: A register write issued while busy leaves every register unchanged. Reads return live contents while busy.
- R4: A commit starts only when register 6 bit 0 changes from 0 to 1. While that bit stays at 1, including after a reload that brings it back as 1, no further commit starts.
- R5: A commit writes all NREG live registers to the store at ascending addresses, with a one-cycle strobe per byte. Busy drops in the cycle after the last byte's done.
- R6: Once register 1 bit 5 is 1 in the store, trigger edges are ignored and busy stays 0. Live register writes still take effect.
- R7: Setting register 1 bit 5 only in the live registers does not lock. A commit still runs.
- R8: The `pin_ctrl_mode` output equals register 2 bit 6 of the last committed or loaded image, not the live value.
- R9: While `out_supply_off` is 1, `pin_ctrl_mode` is 0, and register 1 bits 1:0 (seen on `dev_addr_lsb`) are cleared to 0 from the next cycle on.
- R10: The store write strobe is never high in two consecutive cycles and is high only while busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low power-up reset; release starts a reload |
| reg_we | input | 1 | Register write enable |
| reg_addr | input | AW | Register index for read and write |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data at `reg_addr`, with busy overlay |
| nv_addr | output | AW | Store address |
| nv_wdata | output | 8 | Store write data |
| nv_we | output | 1 | Store write strobe |
| nv_rdata | input | 8 | Store read data at `nv_addr` |
| nv_done | input | 1 | Store write completed |
| out_supply_off | input | 1 | Output supply forced to ground |
| busy | output | 1 | Load or commit in progress |
| lock_active | output | 1 | Committed lock in force |
| pin_ctrl_mode | output | 1 | Dual-use pins act as control pins |
| dev_addr_lsb | output | 2 | Low two device address bits |

## Verification
The bench builds the controller with NREG = 8 and the store model with a write latency of 3. At that size it can sweep every register on write, readback, reload and commit. It can also check each store write against the address order and the expected byte. The short latency brings several complete commits, a power cycle and the locked state within a few hundred cycles.

// File: rtl/cfg_commit_pkg.sv
package cfg_commit_pkg;
    typedef enum logic [1:0] {
        ST_LOAD = 2'd0,
        ST_IDLE = 2'd1,
        ST_PUT  = 2'd2,
        ST_HOLD = 2'd3
    } cc_state_t;

    localparam int DW       = 8;
    localparam int REG_STAT = 1;
    localparam int BUSY_BIT = 6;
    localparam int LOCK_BIT = 5;
    localparam int REG_PIN  = 2;
    localparam int PIN_BIT  = 6;
    localparam int REG_TRIG = 6;
    localparam int TRIG_BIT = 0;
endpackage

// File: rtl/nv_array_model.sv
module nv_array_model #(
    parameter int NREG   = 16,
    parameter int WR_LAT = 4,
    parameter int AW     = $clog2(NREG)
) (
    input  logic          clk,
    input  logic          por_n,
    input  logic [AW-1:0] nv_addr,
    input  logic [7:0]    nv_wdata,
    input  logic          nv_we,
    output logic [7:0]    nv_rdata,
    output logic          nv_done
);
    localparam int CW = $clog2(WR_LAT + 1);

    logic [NREG-1:0][7:0] mem;
    logic [AW-1:0]        pend_addr;
    logic [7:0]           pend_data;
    logic [CW-1:0]        cnt;

    function automatic logic [7:0] factory(input int i);
        return (i == 0) ? 8'h5A : 8'(i * 3);
    endfunction

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            for (int i = 0; i < NREG; i++) mem[i] <= factory(i);
            pend_addr <= '0;
            pend_data <= '0;
            cnt       <= '0;
            nv_done   <= 1'b0;
        end else begin
            nv_done <= 1'b0;
            if (nv_we && cnt == '0) begin
                pend_addr <= nv_addr;
                pend_data <= nv_wdata;
                cnt       <= CW'(WR_LAT);
            end else if (cnt != '0) begin
                cnt <= cnt - 1'b1;
                if (cnt == CW'(1)) begin
                    mem[pend_addr] <= pend_data;
                    nv_done        <= 1'b1;
                end
            end
        end
    end

    assign nv_rdata = mem[nv_addr];
endmodule

// File: rtl/cfg_live_regs.sv
module cfg_live_regs
    import cfg_commit_pkg::*;
#(
    parameter int NREG = 16,
    parameter int AW   = $clog2(NREG)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   host_we,
    input  logic [AW-1:0]          host_addr,
    input  logic [DW-1:0]          host_wdata,
    input  logic                   load_we,
    input  logic [AW-1:0]          load_addr,
    input  logic [DW-1:0]          load_data,
    input  logic                   clr_addr_bits,
    output logic [NREG-1:0][DW-1:0] live
);
    function automatic logic [DW-1:0] scrub(input logic [AW-1:0] a, input logic [DW-1:0] d);
        logic [DW-1:0] r;
        r = d;
        if (a == AW'(REG_STAT)) r[BUSY_BIT] = 1'b0;
        return r;
    endfunction

    for (genvar g = 0; g < NREG; g++) begin : g_reg
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                live[g] <= '0;
            end else begin
                if (load_we && load_addr == AW'(g))
                    live[g] <= scrub(load_addr, load_data);
                else if (host_we && host_addr == AW'(g))
                    live[g] <= scrub(host_addr, host_wdata);
                if (g == REG_STAT && clr_addr_bits)
                    live[g][1:0] <= 2'b00;
            end
        end
    end
endmodule

// File: rtl/cfg_commit_fsm.sv
module cfg_commit_fsm
    import cfg_commit_pkg::*;
#(
    parameter int NREG = 16,
    parameter int AW   = $clog2(NREG)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          trig_live,
    input  logic [DW-1:0] cur_byte,
    input  logic [DW-1:0] nv_rdata,
    input  logic          nv_done,
    output logic [AW-1:0] idx,
    output logic          nv_we,
    output logic          load_we,
    output logic          busy,
    output logic          eff_lock,
    output logic          eff_pin
);
    localparam logic [AW-1:0] LAST = AW'(NREG - 1);

    cc_state_t state, state_nx;
    logic      trig_prev;
    logic      trig_edge;
    logic      byte_stored;

    assign trig_edge   = trig_live && !trig_prev;
    assign byte_stored = (state == ST_HOLD) && nv_done;

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_LOAD: if (idx == LAST) state_nx = ST_IDLE;
            ST_IDLE: if (trig_edge && !eff_lock) state_nx = ST_PUT;
            ST_PUT:  state_nx = ST_HOLD;
            ST_HOLD: if (nv_done) state_nx = (idx == LAST) ? ST_IDLE : ST_PUT;
            default: state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state     <= ST_LOAD;
            idx       <= '0;
            trig_prev <= 1'b0;
        end else begin
            state <= state_nx;
            if (state == ST_LOAD)
                idx <= (idx == LAST) ? '0 : idx + 1'b1;
            else if (state == ST_IDLE && state_nx == ST_PUT)
                idx <= '0;
            else if (byte_stored)
                idx <= (idx == LAST) ? '0 : idx + 1'b1;
            if (load_we && idx == AW'(REG_TRIG))
                trig_prev <= nv_rdata[TRIG_BIT];
            else
                trig_prev <= trig_live;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            eff_lock <= 1'b0;
            eff_pin  <= 1'b0;
        end else if (load_we) begin
            if (idx == AW'(REG_STAT)) eff_lock <= nv_rdata[LOCK_BIT];
            if (idx == AW'(REG_PIN))  eff_pin  <= nv_rdata[PIN_BIT];
        end else if (byte_stored) begin
            if (idx == AW'(REG_STAT)) eff_lock <= cur_byte[LOCK_BIT];
            if (idx == AW'(REG_PIN))  eff_pin  <= cur_byte[PIN_BIT];
        end
    end

    always_comb begin
        load_we = (state == ST_LOAD);
        nv_we   = (state == ST_PUT);
        busy    = (state != ST_IDLE);
    end
endmodule

// File: rtl/cfg_commit_ctrl.sv
module cfg_commit_ctrl
    import cfg_commit_pkg::*;
#(
    parameter int NREG = 16,
    parameter int AW   = $clog2(NREG)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reg_we,
    input  logic [AW-1:0] reg_addr,
    input  logic [7:0]    reg_wdata,
    output logic [7:0]    reg_rdata,
    output logic [AW-1:0] nv_addr,
    output logic [7:0]    nv_wdata,
    output logic          nv_we,
    input  logic [7:0]    nv_rdata,
    input  logic          nv_done,
    input  logic          out_supply_off,
    output logic          busy,
    output logic          lock_active,
    output logic          pin_ctrl_mode,
    output logic [1:0]    dev_addr_lsb
);
    logic [NREG-1:0][DW-1:0] live;
    logic [AW-1:0]           idx;
    logic                    load_we;
    logic                    eff_lock;
    logic                    eff_pin;

    cfg_commit_fsm #(.NREG(NREG), .AW(AW)) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .trig_live(live[REG_TRIG][TRIG_BIT]),
        .cur_byte (live[idx]),
        .nv_rdata (nv_rdata),
        .nv_done  (nv_done),
        .idx      (idx),
        .nv_we    (nv_we),
        .load_we  (load_we),
        .busy     (busy),
        .eff_lock (eff_lock),
        .eff_pin  (eff_pin)
    );

    cfg_live_regs #(.NREG(NREG), .AW(AW)) u_regs (
        .clk          (clk),
        .rst_n        (rst_n),
        .host_we      (reg_we && !busy),
        .host_addr    (reg_addr),
        .host_wdata   (reg_wdata),
        .load_we      (load_we),
        .load_addr    (idx),
        .load_data    (nv_rdata),
        .clr_addr_bits(out_supply_off),
        .live         (live)
    );

    always_comb begin
        reg_rdata = live[reg_addr];
        if (reg_addr == AW'(REG_STAT)) reg_rdata[BUSY_BIT] = busy;
    end

    assign nv_addr       = idx;
    assign nv_wdata      = live[idx];
    assign lock_active   = eff_lock;
    assign pin_ctrl_mode = eff_pin && !out_supply_off;
    assign dev_addr_lsb  = live[REG_STAT][1:0];
endmodule

// File: rtl/cfg_commit_chk.sv
module cfg_commit_chk #(
    parameter int NREG = 16,
    parameter int AW   = $clog2(NREG)
) (
    input logic          clk,
    input logic          rst_n,
    input logic [AW-1:0] reg_addr,
    input logic [7:0]    reg_rdata,
    input logic [AW-1:0] nv_addr,
    input logic          nv_we,
    input logic          nv_done,
    input logic          out_supply_off,
    input logic          busy,
    input logic          lock_active,
    input logic          pin_ctrl_mode,
    input logic [1:0]    dev_addr_lsb
);
    p_busy_flag_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == AW'(1)) |-> (reg_rdata[6] == busy));

    p_finish_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && nv_done && nv_addr == AW'(NREG - 1)) |=> !busy);

    p_locked_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (lock_active && !busy) |=> !busy);

    p_serial_pins_r9: assert property (@(posedge clk) disable iff (!rst_n)
        out_supply_off |-> !pin_ctrl_mode);

    p_addr_cleared_r9: assert property (@(posedge clk) disable iff (!rst_n)
        out_supply_off |=> (dev_addr_lsb == 2'b00));

    p_strobe_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        nv_we |=> !nv_we);

    p_strobe_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
        nv_we |-> busy);
endmodule

bind cfg_commit_ctrl cfg_commit_chk #(.NREG(NREG), .AW(AW)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .reg_addr      (reg_addr),
    .reg_rdata     (reg_rdata),
    .nv_addr       (nv_addr),
    .nv_we         (nv_we),
    .nv_done       (nv_done),
    .out_supply_off(out_supply_off),
    .busy          (busy),
    .lock_active   (lock_active),
    .pin_ctrl_mode (pin_ctrl_mode),
    .dev_addr_lsb  (dev_addr_lsb)
);

// File: tb/cfg_commit_ctrl_tb_top.sv
module cfg_commit_ctrl_tb_top;
    localparam int NREG = 8;
    localparam int AW   = 3;
    localparam int LAT  = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          por_n = 1'b0;
    logic          reg_we = 1'b0;
    logic [AW-1:0] reg_addr = '0;
    logic [7:0]    reg_wdata = '0;
    logic [7:0]    reg_rdata;
    logic [AW-1:0] nv_addr;
    logic [7:0]    nv_wdata;
    logic          nv_we;
    logic [7:0]    nv_rdata;
    logic          nv_done;
    logic          out_supply_off = 1'b0;
    logic          busy;
    logic          lock_active;
    logic          pin_ctrl_mode;
    logic [1:0]    dev_addr_lsb;

    int checks = 0;
    int errors = 0;
    int nv_cnt = 0;
    int nv_idx = 0;
    bit finished = 0;
    logic [7:0] exp_live [NREG];

    always #4 clk = ~clk;

    cfg_commit_ctrl #(.NREG(NREG), .AW(AW)) dut_i (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .nv_addr(nv_addr),
        .nv_wdata(nv_wdata), .nv_we(nv_we), .nv_rdata(nv_rdata), .nv_done(nv_done),
        .out_supply_off(out_supply_off), .busy(busy), .lock_active(lock_active),
        .pin_ctrl_mode(pin_ctrl_mode), .dev_addr_lsb(dev_addr_lsb)
    );

    nv_array_model #(.NREG(NREG), .WR_LAT(LAT), .AW(AW)) u_store (
        .clk(clk), .por_n(por_n), .nv_addr(nv_addr), .nv_wdata(nv_wdata),
        .nv_we(nv_we), .nv_rdata(nv_rdata), .nv_done(nv_done)
    );

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // store write monitor: ascending addresses, data equal to expected live copy (R5)
    always @(negedge clk) begin
        if (rst_n && nv_we) begin
            chk("R5 store address", 8'(nv_addr), 8'(nv_idx));
            chk("R5 store data", nv_wdata, exp_live[nv_addr]);
            nv_idx++;
            nv_cnt++;
        end
    end

    task automatic wr(input int a, input logic [7:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = AW'(a); reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input int a, output logic [7:0] d);
        @(negedge clk);
        reg_addr = AW'(a);
        #1 d = reg_rdata;
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 400 && busy; i++) @(negedge clk);
    endtask

    task automatic sweep_read(input string tag);
        logic [7:0] d;
        for (int i = 0; i < NREG; i++) begin
            rd(i, d);
            chk(tag, d, exp_live[i]);
        end
    endtask

    function automatic logic [7:0] pat(input int i);
        logic [7:0] v;
        v = 8'(i * 37 + 11);
        if (i == 1) begin v[6] = 1'b0; v[5] = 1'b0; v[1:0] = 2'b11; end
        if (i == 2) v[6] = 1'b1;
        if (i == 6) v[0] = 1'b0;
        return v;
    endfunction

    task automatic commit(input string tag, input int expect_run);
        logic [7:0] d;
        nv_idx = 0; nv_cnt = 0;
        wr(6, exp_live[6] & 8'hFE);
        exp_live[6] = exp_live[6] & 8'hFE;
        exp_live[6][0] = 1'b1;
        wr(6, exp_live[6]);
        @(negedge clk); #1;
        chk({tag, " busy after edge"}, 8'(busy), 8'(expect_run));
        if (expect_run != 0) begin
            wr(3, 8'hC3);                       // refused while busy (R3)
            rd(1, d);
            chk("R2 busy bit reads 1", 8'(d[6]), 8'd1);
            rd(3, d);
            chk("R3 read served and write refused", d, exp_live[3]);
        end
        wait_idle();
        repeat (8) @(negedge clk);
        chk({tag, " store writes"}, 8'(nv_cnt), 8'(expect_run != 0 ? NREG : 0));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [7:0] d;
        for (int i = 0; i < NREG; i++) exp_live[i] = (i == 0) ? 8'h5A : 8'(i * 3);
        repeat (3) @(negedge clk);
        por_n = 1'b1;
        rst_n = 1'b1;
        @(negedge clk); #1;
        chk("R1 busy during load", 8'(busy), 8'd1);
        wait_idle();
        chk("R2 idle after load", 8'(busy), 8'd0);
        sweep_read("R1 factory image loaded");
        chk("R8 reset pin mode", 8'(pin_ctrl_mode), 8'd0);
        chk("R6 reset lock", 8'(lock_active), 8'd0);

        // live write sweep
        for (int i = 0; i < NREG; i++) begin
            wr(i, pat(i));
            exp_live[i] = pat(i);
        end
        wr(1, pat(1) | 8'h40);                  // bit 6 not storable (R2)
        sweep_read("R3 live write readback");
        chk("R8 live pin bit alone", 8'(pin_ctrl_mode), 8'd0);
        chk("R9 address bits live", 8'(dev_addr_lsb), 8'd3);

        commit("R4 first commit", 1);
        chk("R8 pin mode after commit", 8'(pin_ctrl_mode), 8'd1);
        chk("R6 unlocked after commit", 8'(lock_active), 8'd0);

        // trigger held high: no new commit (R4)
        nv_cnt = 0;
        repeat (20) @(negedge clk);
        chk("R4 held trigger idle", 8'(busy), 8'd0);
        chk("R4 held trigger no writes", 8'(nv_cnt), 8'd0);

        // live lock only (R7)
        exp_live[1][5] = 1'b1;
        wr(1, exp_live[1]);
        chk("R7 live lock no effect", 8'(lock_active), 8'd0);
        commit("R7 commit with live lock", 1);
        chk("R6 lock after commit", 8'(lock_active), 8'd1);

        // locked: edge ignored, live writes effective (R6)
        commit("R6 locked trigger", 0);
        wr(4, 8'h9C);
        rd(4, d);
        chk("R6 live write while locked", d, 8'h9C);
        exp_live[4] = 8'h9C;

        // supply off (R9)
        @(negedge clk); out_supply_off = 1'b1;
        @(negedge clk); #1;
        chk("R9 pin mode serial", 8'(pin_ctrl_mode), 8'd0);
        chk("R9 address bits cleared", 8'(dev_addr_lsb), 8'd0);
        exp_live[1][1:0] = 2'b00;
        rd(1, d);
        chk("R9 register 1 readback", d, exp_live[1]);
        @(negedge clk); out_supply_off = 1'b0;
        @(negedge clk); #1;
        chk("R9 pin mode restored", 8'(pin_ctrl_mode), 8'd1);

        // power down/up: reload last committed image (R1)
        for (int i = 0; i < NREG; i++) exp_live[i] = pat(i);
        exp_live[1][5] = 1'b1;
        exp_live[6][0] = 1'b1;
        @(negedge clk); rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        nv_cnt = 0;
        wr(3, 8'h11);                           // during load: refused (R3)
        wait_idle();
        repeat (10) @(negedge clk);
        sweep_read("R1 reload committed image");
        chk("R6 lock restored from store", 8'(lock_active), 8'd1);
        chk("R8 pin restored from store", 8'(pin_ctrl_mode), 8'd1);
        chk("R4 no commit after reload", 8'(nv_cnt), 8'd0);

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule